// File: doc/BRIEF.md
# Variable-Length Fiber Cache Tag Lookup

This block is the tag side of a read-only on-chip cache for sparse tensor fibers. Fibers vary in length, while the data array uses fixed 64-byte blocks of eight 8-byte elements. A block can hold several short fibers with consecutive IDs. A long fiber can be cut into segments, and each segment takes a block of its own. The block answers lookups of the form (fiber ID, element offset) with hit or miss, the physical block index and the element position inside that block. After a miss, the requester installs the tag with a fill request. The data array, the memory port and any real replacement policy sit outside this block. Victims are chosen round-robin per set.

The cache is 4-way set-associative with a parameterised set count. Each way holds either a packed entry or a split entry. A packed entry holds a base ID, a fiber count of 1 to 4 and the start element of each packed sub-fiber. A split entry holds the low 16 bits of the fiber ID and a segment number. A lookup reads one set and compares it against both entry kinds in parallel. The lookup controller has two states. In LK_IDLE it waits for a request; an accepted request moves it to LK_HOLD. In LK_HOLD it presents the response. It returns to LK_IDLE when the response is taken and no new request arrives. It stays in LK_HOLD when a new request is accepted in the same cycle the response is taken.

Top module: `fiber_tag_lookup`

## Requirements
- R1: After reset, every way is invalid, `rsp_valid` and `fill_ack` are low, and `req_ready` is high.
- R2: An accepted request (`req_valid` and `req_ready`) gives `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay stable and `req_ready` is low.
- R3: The segment number is `req_off / 8`. The set index is `fiber_id[3:2] XOR segment[1:0]`. Packed entries and packed lookups use segment 0 for this.
- R4: A packed entry with base B and count C hits for a fiber ID X under three conditions. X shares bits [31:2] with B. X[1:0] is at least B[1:0]. X[1:0] is below B[1:0]+C. The block offset is then start[X[1:0]-B[1:0]] + offset.
- R5: A packed sub-fiber k runs from start[k] to start[k+1]. The last sub-fiber (k = C-1) runs to element 8. A packed lookup hits only when offset < 8 and start[k]+offset lies below that end.
- R6: A split entry hits when the stored ID bits [15:0] equal the request ID bits [15:0] and the stored segment equals `req_off / 8`. The block offset is `req_off % 8`. ID bits above 15 are not compared.
- R7: A split fill with segment >= 4096 is acknowledged with `fill_err` high and writes nothing. A lookup with `req_off` >= 32768 always misses.
- R8: A packed fill is acknowledged with `fill_err` high and writes nothing in two cases: the count is 0, or B[1:0]+C exceeds 4 (the range would leave its aligned window of 4 IDs).
- R9: Each set has its own round-robin pointer, starting at way 0, that moves forward by one on every accepted fill. `rsp_blk` = set*4 + way. On several matches, the lowest way wins.
- R10: `fill_ready` is always high. Each fill gets `fill_ack` exactly one cycle later, and `fill_ack` is never high without a fill.
- R11: A lookup accepted in the same cycle as a fill sees the tag state from before that fill.
- R12: A miss returns `rsp_hit` = 0, `rsp_blk` = 0 and `rsp_boff` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_id | input | 32 | Fiber ID to look up |
| req_off | input | 16 | Element offset within the fiber |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Tag matched |
| rsp_blk | output | 4 | Physical block index (set*4+way) |
| rsp_boff | output | 3 | Element position within the block |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill can be accepted (always high) |
| fill_id | input | 32 | Base fiber ID (packed) or fiber ID (split) |
| fill_cnt | input | 3 | Number of packed fibers |
| fill_starts | input | 12 | Four 3-bit start elements; sub-fiber k at bits [3k+2:3k] |
| fill_split | input | 1 | 1: split segment entry, 0: packed entry |
| fill_seg | input | 13 | Segment number for a split fill |
| fill_ack | output | 1 | Fill completed |
| fill_err | output | 1 | Fill rejected (limit or window violation) |

## Verification
The properties assume that request fields stay known while `req_valid` is high. They also assume that `fill_starts` rises across the packed sub-fibers. Without that, the sub-fiber lengths in R5 have no meaning. The stimulus never installs a fiber ID or segment that is already resident in its set. This keeps the lowest-way priority from hiding a bad entry. The sweeps use a reference model that applies the rules above on its own and follows round-robin eviction. That model is how they cover overlapping cases such as a same-cycle fill and lookup.

// File: rtl/fiber_tag_pkg.sv
package fiber_tag_pkg;

    typedef enum logic [0:0] {
        LK_IDLE = 1'b0,
        LK_HOLD = 1'b1
    } lk_state_e;

    typedef enum logic [0:0] {
        KIND_PACKED = 1'b0,
        KIND_SPLIT  = 1'b1
    } entry_kind_e;

endpackage

// File: rtl/fiber_set_hash.sv
module fiber_set_hash #(
    parameter int ID_W   = 32,
    parameter int SEGQ_W = 13,
    parameter int PK_W   = 2,
    parameter int SET_W  = 2
) (
    input  logic [ID_W-1:0]   id,
    input  logic [SEGQ_W-1:0] seg,
    output logic [SET_W-1:0]  set_idx
);
    // IDs inside one packing window share a set; segments spread across sets
    assign set_idx = id[PK_W +: SET_W] ^ seg[SET_W-1:0];
endmodule

// File: rtl/fiber_tag_store.sv
module fiber_tag_store #(
    parameter int SETS     = 4,
    parameter int WAYS     = 4,
    parameter int ID_W     = 32,
    parameter int CNT_W    = 3,
    parameter int SEG_W    = 12,
    parameter int PACK_MAX = 4,
    parameter int EB_W     = 3,
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic [SET_W-1:0]                         wr_set,
    input  logic                                     wr_split,
    input  logic [ID_W-1:0]                          wr_id,
    input  logic [CNT_W-1:0]                         wr_cnt,
    input  logic [SEG_W-1:0]                         wr_seg,
    input  logic [PACK_MAX-1:0][EB_W-1:0]            wr_starts,
    output logic [WAY_W-1:0]                         wr_way,
    input  logic [SET_W-1:0]                         rd_set,
    output logic [WAYS-1:0]                          rd_valid,
    output logic [WAYS-1:0]                          rd_split,
    output logic [WAYS-1:0][ID_W-1:0]                rd_id,
    output logic [WAYS-1:0][CNT_W-1:0]               rd_cnt,
    output logic [WAYS-1:0][SEG_W-1:0]               rd_seg,
    output logic [WAYS-1:0][PACK_MAX-1:0][EB_W-1:0]  rd_starts
);
    logic [SETS-1:0][WAYS-1:0]                         valid_q;
    logic [SETS-1:0][WAYS-1:0]                         split_q;
    logic [SETS-1:0][WAYS-1:0][ID_W-1:0]               id_q;
    logic [SETS-1:0][WAYS-1:0][CNT_W-1:0]              cnt_q;
    logic [SETS-1:0][WAYS-1:0][SEG_W-1:0]              seg_q;
    logic [SETS-1:0][WAYS-1:0][PACK_MAX-1:0][EB_W-1:0] starts_q;
    logic [SETS-1:0][WAY_W-1:0]                        rr_q;

    assign wr_way = rr_q[wr_set];

    // control state: valid bits and per-set victim pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
            rr_q[wr_set]            <= rr_q[wr_set] + 1'b1;
        end
    end

    // payload: no reset needed, qualified by valid
    always_ff @(posedge clk) begin
        if (wr_en) begin
            split_q[wr_set][wr_way]  <= wr_split;
            id_q[wr_set][wr_way]     <= wr_id;
            cnt_q[wr_set][wr_way]    <= wr_cnt;
            seg_q[wr_set][wr_way]    <= wr_seg;
            starts_q[wr_set][wr_way] <= wr_starts;
        end
    end

    // read port sees state before any write of this cycle
    assign rd_valid  = valid_q[rd_set];
    assign rd_split  = split_q[rd_set];
    assign rd_id     = id_q[rd_set];
    assign rd_cnt    = cnt_q[rd_set];
    assign rd_seg    = seg_q[rd_set];
    assign rd_starts = starts_q[rd_set];
endmodule

// File: rtl/fiber_way_cmp.sv
module fiber_way_cmp #(
    parameter int ID_W     = 32,
    parameter int OFF_W    = 16,
    parameter int SEG_W    = 12,
    parameter int PACK_MAX = 4,
    parameter int EB_W     = 3,
    parameter int TAG_LO_W = 16,
    localparam int PK_W    = $clog2(PACK_MAX),
    localparam int CNT_W   = PK_W + 1,
    localparam int SEGQ_W  = OFF_W - EB_W
) (
    input  logic                          ent_valid,
    input  logic                          ent_split,
    input  logic [ID_W-1:0]               ent_id,
    input  logic [CNT_W-1:0]              ent_cnt,
    input  logic [SEG_W-1:0]              ent_seg,
    input  logic [PACK_MAX-1:0][EB_W-1:0] ent_starts,
    input  logic [ID_W-1:0]               q_id,
    input  logic [OFF_W-1:0]              q_off,
    input  logic [SEGQ_W-1:0]             q_seg,
    output logic                          hit,
    output logic [EB_W-1:0]               boff
);
    localparam int EPB       = 1 << EB_W;
    localparam int SEG_LIMIT = 1 << SEG_W;

    logic [PK_W-1:0] k_idx;
    logic [PK_W-1:0] k_next;
    logic [EB_W:0]   sub_start;
    logic [EB_W:0]   sub_end;
    logic [EB_W:0]   pos;
    logic            win_eq;
    logic            lo_ok;
    logic            hi_ok;
    logic            off_small;
    logic            pk_hit;
    logic            sp_hit;

    always_comb begin
        win_eq    = (q_id[ID_W-1:PK_W] == ent_id[ID_W-1:PK_W]);
        lo_ok     = (q_id[PK_W-1:0] >= ent_id[PK_W-1:0]);
        hi_ok     = ({1'b0, q_id[PK_W-1:0]} < ({1'b0, ent_id[PK_W-1:0]} + ent_cnt));
        k_idx     = q_id[PK_W-1:0] - ent_id[PK_W-1:0];
        k_next    = k_idx + 1'b1;
        sub_start = {1'b0, ent_starts[k_idx]};
        if ({1'b0, k_idx} == (ent_cnt - 1'b1)) begin
            sub_end = (EB_W+1)'(EPB);
        end else begin
            sub_end = {1'b0, ent_starts[k_next]};
        end
        off_small = (q_off < OFF_W'(EPB));
        pos       = sub_start + {1'b0, q_off[EB_W-1:0]};
        pk_hit    = ent_valid && !ent_split && win_eq && lo_ok && hi_ok
                    && off_small && (pos < sub_end);
        sp_hit    = ent_valid && ent_split
                    && (ent_id[TAG_LO_W-1:0] == q_id[TAG_LO_W-1:0])
                    && (q_seg < SEGQ_W'(SEG_LIMIT))
                    && (q_seg[SEG_W-1:0] == ent_seg);
        hit       = pk_hit || sp_hit;
        boff      = pk_hit ? pos[EB_W-1:0] : q_off[EB_W-1:0];
    end
endmodule

// File: rtl/fiber_tag_lookup.sv
module fiber_tag_lookup
    import fiber_tag_pkg::*;
#(
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int ID_W       = 32,
    parameter int OFF_W      = 16,
    parameter int BLK_BYTES  = 64,
    parameter int ELEM_BYTES = 8,
    parameter int PACK_MAX   = 4,
    parameter int SEG_W      = 12,
    parameter int TAG_LO_W   = 16,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int EB_W      = $clog2(BLK_BYTES / ELEM_BYTES),
    localparam int PK_W      = $clog2(PACK_MAX),
    localparam int CNT_W     = PK_W + 1,
    localparam int SEGQ_W    = OFF_W - EB_W,
    localparam int FSEG_W    = SEG_W + 1,
    localparam int BLK_W     = SET_W + WAY_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ID_W-1:0]          req_id,
    input  logic [OFF_W-1:0]         req_off,
    output logic                     rsp_valid,
    input  logic                     rsp_ready,
    output logic                     rsp_hit,
    output logic [BLK_W-1:0]         rsp_blk,
    output logic [EB_W-1:0]          rsp_boff,
    input  logic                     fill_valid,
    output logic                     fill_ready,
    input  logic [ID_W-1:0]          fill_id,
    input  logic [CNT_W-1:0]         fill_cnt,
    input  logic [PACK_MAX*EB_W-1:0] fill_starts,
    input  logic                     fill_split,
    input  logic [FSEG_W-1:0]        fill_seg,
    output logic                     fill_ack,
    output logic                     fill_err
);
    localparam int SEG_LIMIT = 1 << SEG_W;

    // ---------------- lookup address ----------------
    logic [SEGQ_W-1:0] lk_seg;
    logic [SET_W-1:0]  lk_set;

    assign lk_seg = req_off[OFF_W-1:EB_W];

    fiber_set_hash #(
        .ID_W(ID_W), .SEGQ_W(SEGQ_W), .PK_W(PK_W), .SET_W(SET_W)
    ) lk_hash_i (
        .id(req_id), .seg(lk_seg), .set_idx(lk_set)
    );

    // ---------------- fill address and checks ----------------
    logic [SEGQ_W-1:0]            fl_seg_h;
    logic [SET_W-1:0]             fl_set;
    logic                         fl_err;
    logic                         fl_we;
    logic [WAY_W-1:0]             fl_way;
    logic [PACK_MAX-1:0][EB_W-1:0] fl_starts;
    entry_kind_e                  fl_kind;

    assign fl_kind   = fill_split ? KIND_SPLIT : KIND_PACKED;
    assign fl_seg_h  = (fl_kind == KIND_SPLIT) ? SEGQ_W'(fill_seg) : '0;
    assign fl_starts = fill_starts;

    fiber_set_hash #(
        .ID_W(ID_W), .SEGQ_W(SEGQ_W), .PK_W(PK_W), .SET_W(SET_W)
    ) fl_hash_i (
        .id(fill_id), .seg(fl_seg_h), .set_idx(fl_set)
    );

    always_comb begin
        unique case (fl_kind)
            KIND_SPLIT:  fl_err = (fill_seg >= FSEG_W'(SEG_LIMIT));
            KIND_PACKED: fl_err = (fill_cnt == '0)
                                  || (fill_cnt > CNT_W'(PACK_MAX))
                                  || (({1'b0, fill_id[PK_W-1:0]} + fill_cnt) > CNT_W'(PACK_MAX));
        endcase
    end

    assign fl_we      = fill_valid && !fl_err;
    assign fill_ready = 1'b1;

    // ---------------- tag storage ----------------
    logic [WAYS-1:0]                         rd_valid;
    logic [WAYS-1:0]                         rd_split;
    logic [WAYS-1:0][ID_W-1:0]               rd_id;
    logic [WAYS-1:0][CNT_W-1:0]              rd_cnt;
    logic [WAYS-1:0][SEG_W-1:0]              rd_seg;
    logic [WAYS-1:0][PACK_MAX-1:0][EB_W-1:0] rd_starts;

    fiber_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .ID_W(ID_W), .CNT_W(CNT_W),
        .SEG_W(SEG_W), .PACK_MAX(PACK_MAX), .EB_W(EB_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fl_we), .wr_set(fl_set), .wr_split(fill_split),
        .wr_id(fill_id), .wr_cnt(fill_cnt), .wr_seg(fill_seg[SEG_W-1:0]),
        .wr_starts(fl_starts), .wr_way(fl_way),
        .rd_set(lk_set), .rd_valid(rd_valid), .rd_split(rd_split),
        .rd_id(rd_id), .rd_cnt(rd_cnt), .rd_seg(rd_seg), .rd_starts(rd_starts)
    );

    // ---------------- per-way comparison ----------------
    logic [WAYS-1:0]           way_hit;
    logic [WAYS-1:0][EB_W-1:0] way_boff;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        fiber_way_cmp #(
            .ID_W(ID_W), .OFF_W(OFF_W), .SEG_W(SEG_W),
            .PACK_MAX(PACK_MAX), .EB_W(EB_W), .TAG_LO_W(TAG_LO_W)
        ) cmp_i (
            .ent_valid(rd_valid[w]), .ent_split(rd_split[w]),
            .ent_id(rd_id[w]), .ent_cnt(rd_cnt[w]), .ent_seg(rd_seg[w]),
            .ent_starts(rd_starts[w]),
            .q_id(req_id), .q_off(req_off), .q_seg(lk_seg),
            .hit(way_hit[w]), .boff(way_boff[w])
        );
    end

    logic             any_hit;
    logic [WAY_W-1:0] hit_way;
    logic [EB_W-1:0]  hit_boff;

    // lowest matching way wins
    always_comb begin
        any_hit  = 1'b0;
        hit_way  = '0;
        hit_boff = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                any_hit  = 1'b1;
                hit_way  = WAY_W'(w);
                hit_boff = way_boff[w];
            end
        end
    end

    // ---------------- lookup controller ----------------
    lk_state_e state_q;
    lk_state_e state_d;
    logic      accept;

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: if (req_valid)               state_d = LK_HOLD;
            LK_HOLD: if (rsp_ready && !req_valid) state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LK_IDLE: begin
                rsp_valid = 1'b0;
                req_ready = 1'b1;
            end
            LK_HOLD: begin
                rsp_valid = 1'b1;
                req_ready = rsp_ready;
            end
        endcase
    end

    logic             hit_q;
    logic [BLK_W-1:0] blk_q;
    logic [EB_W-1:0]  boff_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            blk_q  <= '0;
            boff_q <= '0;
        end else if (accept) begin
            hit_q  <= any_hit;
            blk_q  <= any_hit ? {lk_set, hit_way} : '0;
            boff_q <= any_hit ? hit_boff : '0;
        end
    end

    assign rsp_hit  = hit_q;
    assign rsp_blk  = blk_q;
    assign rsp_boff = boff_q;

    // ---------------- fill acknowledge ----------------
    logic ack_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ack_q <= fill_valid;
            err_q <= fill_valid && fl_err;
        end
    end

    assign fill_ack = ack_q;
    assign fill_err = err_q;
endmodule

// File: rtl/fiber_tag_lookup_chk.sv
module fiber_tag_lookup_chk #(
    parameter int OFF_W     = 16,
    parameter int BLK_W     = 4,
    parameter int EB_W      = 3,
    parameter int SEG_W     = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] req_off,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             rsp_hit,
    input logic [BLK_W-1:0] rsp_blk,
    input logic [EB_W-1:0]  rsp_boff,
    input logic             fill_valid,
    input logic             fill_ack
);
    localparam longint LIMIT_OFF = (longint'(1) << SEG_W) << EB_W;

    // R2
    rsp_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit)
                                    && $stable(rsp_blk) && $stable(rsp_boff));

    // R2
    req_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    // R2
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    // R7
    seg_limit_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (longint'(req_off) >= LIMIT_OFF) |=> !rsp_hit);

    // R12
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> (rsp_blk == '0) && (rsp_boff == '0));

    // R10
    fill_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> fill_ack);

    // R10
    no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> !fill_ack);
endmodule

bind fiber_tag_lookup fiber_tag_lookup_chk #(
    .OFF_W(OFF_W), .BLK_W(BLK_W), .EB_W(EB_W), .SEG_W(SEG_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_blk(rsp_blk), .rsp_boff(rsp_boff),
    .fill_valid(fill_valid), .fill_ack(fill_ack)
);

// File: tb/fiber_tag_lookup_tb_top.sv
module fiber_tag_lookup_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_id = '0;
    logic [15:0] req_off = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_hit;
    logic [3:0]  rsp_blk;
    logic [2:0]  rsp_boff;
    logic        fill_valid = 1'b0;
    logic        fill_ready;
    logic [31:0] fill_id = '0;
    logic [2:0]  fill_cnt = '0;
    logic [11:0] fill_starts = '0;
    logic        fill_split = 1'b0;
    logic [12:0] fill_seg = '0;
    logic        fill_ack;
    logic        fill_err;

    always #2 clk = ~clk;

    fiber_tag_lookup dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_blk(rsp_blk), .rsp_boff(rsp_boff),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_id(fill_id),
        .fill_cnt(fill_cnt), .fill_starts(fill_starts), .fill_split(fill_split),
        .fill_seg(fill_seg), .fill_ack(fill_ack), .fill_err(fill_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference tag state, entry index = set*4 + way
    bit          m_v  [16];
    bit          m_sp [16];
    logic [31:0] m_id [16];
    int          m_cnt[16];
    int          m_seg[16];
    int          m_st [16][4];
    int          m_rr [4];

    task automatic check(input string req, input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // R3 set index
    function automatic int hset(input logic [31:0] id, input int seg);
        return (int'(id[3:2]) ^ (seg & 3));
    endfunction

    // R4 R5 R6 R7 R9 R12 expected result
    task automatic model_lookup(input logic [31:0] id, input int off,
                                output bit hit, output int blk, output int boff);
        int seg = off / 8;
        int s = hset(id, seg);
        hit = 0; blk = 0; boff = 0;
        for (int w = 0; w < 4; w++) begin
            int e = s * 4 + w;
            if (!hit && m_v[e]) begin
                if (!m_sp[e]) begin
                    int lo = int'(id[1:0]);
                    int bl = int'(m_id[e][1:0]);
                    if (id[31:2] == m_id[e][31:2] && lo >= bl && lo < bl + m_cnt[e] && off < 8) begin
                        int k = lo - bl;
                        int st = m_st[e][k];
                        int en = (k == m_cnt[e] - 1) ? 8 : m_st[e][k + 1];
                        if (st + off < en) begin
                            hit = 1; blk = e; boff = st + off;
                        end
                    end
                end else if (id[15:0] == m_id[e][15:0] && seg < 4096 && seg == m_seg[e]) begin
                    hit = 1; blk = e; boff = off % 8;
                end
            end
        end
    endtask

    function automatic bit fill_bad(input logic [31:0] id, input int cnt, input bit sp, input int seg);
        if (sp) return seg >= 4096;
        return (cnt == 0) || (cnt > 4) || (int'(id[1:0]) + cnt > 4);
    endfunction

    task automatic model_write(input logic [31:0] id, input int cnt, input int st[4],
                               input bit sp, input int seg);
        int s = hset(id, sp ? seg : 0);
        int e = s * 4 + m_rr[s];
        m_v[e] = 1; m_sp[e] = sp; m_id[e] = id; m_cnt[e] = cnt; m_seg[e] = seg;
        for (int k = 0; k < 4; k++) m_st[e][k] = st[k];
        m_rr[s] = (m_rr[s] + 1) % 4;
    endtask

    task automatic drive_fill(input logic [31:0] id, input int cnt, input int st[4],
                              input bit sp, input int seg);
        fill_valid  = 1'b1;
        fill_id     = id;
        fill_cnt    = 3'(cnt);
        fill_split  = sp;
        fill_seg    = 13'(seg);
        fill_starts = {3'(st[3]), 3'(st[2]), 3'(st[1]), 3'(st[0])};
    endtask

    task automatic cmp_rsp(input string req, input logic [31:0] id, input int off,
                           input bit eh, input int eb, input int eo);
        check(req, rsp_valid === 1'b1 && rsp_hit === eh && int'(rsp_blk) == eb
                   && int'(rsp_boff) == eo,
              $sformatf("id=%0h off=%0d actual v=%b hit=%b blk=%0d boff=%0d expected hit=%b blk=%0d boff=%0d",
                        id, off, rsp_valid, rsp_hit, rsp_blk, rsp_boff, eh, eb, eo));
    endtask

    task automatic do_lookup(input string req, input logic [31:0] id, input int off);
        bit eh; int eb; int eo;
        model_lookup(id, off, eh, eb, eo);
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_off = 16'(off);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cmp_rsp(req, id, off, eh, eb, eo);
    endtask

    task automatic do_fill(input string req, input logic [31:0] id, input int cnt,
                           input int st[4], input bit sp, input int seg);
        bit bad = fill_bad(id, cnt, sp, seg);
        @(negedge clk);
        drive_fill(id, cnt, st, sp, seg);
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        check(req, fill_ack === 1'b1 && fill_err === bad,
              $sformatf("fill id=%0h actual ack=%b err=%b expected ack=1 err=%b",
                        id, fill_ack, fill_err, bad));
        if (!bad) model_write(id, cnt, st, sp, seg);
    endtask

    task automatic sweep(input string req);
        for (int id = 0; id < 21; id++)
            for (int off = 0; off < 10; off++)
                do_lookup(req, 32'(id), off);
        for (int off = 0; off < 40; off++) begin
            do_lookup("R6", 32'h0001_2345, off);
            do_lookup("R6", 32'h0003_2345, off);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int z[4]  = '{0, 0, 0, 0};
        int pa[4] = '{0, 2, 3, 6};
        int pb[4] = '{0, 4, 0, 0};
        bit eh; int eb; int eo;
        for (int i = 0; i < 16; i++) m_v[i] = 0;
        for (int i = 0; i < 4; i++) m_rr[i] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1", rsp_valid === 1'b0 && fill_ack === 1'b0 && req_ready === 1'b1 && fill_ready === 1'b1,
              $sformatf("actual rsp_valid=%b ack=%b req_ready=%b expected 0 0 1",
                        rsp_valid, fill_ack, req_ready));
        do_lookup("R1", 32'd0, 0);

        // R4 R5 packed entries, R6 split segments, R9 placement
        do_fill("R4", 32'd0, 4, pa, 0, 0);
        do_fill("R4", 32'd5, 2, pb, 0, 0);
        do_fill("R5", 32'd9, 1, z, 0, 0);
        for (int s = 0; s < 4; s++) do_fill("R6", 32'h0001_2345, 1, z, 1, s);
        do_fill("R7", 32'h0001_2345, 1, z, 1, 4095);
        // R8 rejected packed fills, R7 rejected segment
        do_fill("R8", 32'd10, 3, z, 0, 0);
        do_fill("R8", 32'd20, 0, z, 0, 0);
        do_fill("R7", 32'h0000_0777, 1, z, 1, 4096);
        sweep("R4");
        do_lookup("R7", 32'h0001_2345, 32767);
        do_lookup("R7", 32'h0001_2345, 32768);
        do_lookup("R7", 32'h0000_0777, 32768);

        // R9 eviction in set 3
        for (int i = 12; i < 16; i++) do_fill("R9", 32'(i), 1, z, 0, 0);
        sweep("R9");

        // R11 same-cycle fill and lookup to set 0
        model_lookup(32'd16, 0, eh, eb, eo);
        @(negedge clk);
        drive_fill(32'd16, 2, pb, 0, 0);
        req_valid = 1'b1; req_id = 32'd16; req_off = '0;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0;
        cmp_rsp("R11", 32'd16, 0, eh, eb, eo);
        check("R10", fill_ack === 1'b1 && fill_err === 1'b0,
              $sformatf("actual ack=%b err=%b expected 1 0", fill_ack, fill_err));
        model_write(32'd16, 2, pb, 0, 0);
        @(negedge clk);
        check("R10", fill_ack === 1'b0, $sformatf("actual ack=%b expected 0", fill_ack));
        do_lookup("R11", 32'd16, 0);
        do_lookup("R11", 32'd17, 3);

        // R2 backpressure
        model_lookup(32'd1, 1, eh, eb, eo);
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; req_id = 32'd1; req_off = 16'd1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cmp_rsp("R2", 32'd1, 1, eh, eb, eo);
            check("R2", req_ready === 1'b0, $sformatf("actual req_ready=%b expected 0", req_ready));
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R2", rsp_valid === 1'b0 && req_ready === 1'b1,
              $sformatf("actual rsp_valid=%b req_ready=%b expected 0 1", rsp_valid, req_ready));

        done = 1;
        finish_run();
    end
endmodule